// File: doc/BRIEF.md
# Set-Associative Translation Cache

This block holds recently used page table entries so that a virtual address can be turned into a physical address without going to memory. A lookup takes the virtual page number, uses its low bits to select a set and its high bits as a tag, and compares that tag with every valid way of the set. On a match the stored entry and the rebuilt physical address come out in the same cycle. Otherwise a miss is raised. An external walker then fetches the entry and writes it back through the fill port.

Each set keeps a record of its most recently used way, which decides where a fill goes when the set is full. A flush input drops every entry at once. Permission checks and table walking are done elsewhere. With the default parameters the virtual address is 32 bits (a 20-bit page number above a 12-bit offset). There are 4 sets of 2 ways. Each entry is 24 bits: a 20-bit physical page number in bits [23:4] and 4 flag bits in [3:0], which are stored and returned unchanged.

Top module: `tlb_sa`

## Requirements
- R1: The set index is virtual address bits [13:12], the two page-number bits just above the offset. The tag is bits [31:14]. An address that differs from a stored one in either field does not hit.
- R2: When `lk_valid` is high and `flush` is low, a valid way in the indexed set whose tag equals the lookup tag raises `lk_hit` in the same cycle, and `lk_pte` carries that way's stored entry.
- R3: On a hit, `lk_paddr` equals the entry's bits [23:4] followed by virtual address bits [11:0].
- R4: `lk_miss` is high exactly when `lk_valid` is high and `lk_hit` is low. With `lk_valid` low, both are low.
- R5: A fill with `flush` low writes `fill_pte` into the set chosen by `fill_vpn[1:0]`, tagged with `fill_vpn[19:2]`. It becomes visible from the next cycle. A lookup in the fill's own cycle sees the old contents.
- R6: A fill for a page not present in its set goes to the lowest-numbered invalid way, if one exists.
- R7: When every way of the set is valid, a fill replaces the least recently used way. Both hits and fills count as uses.
- R8: A fill for a page already present overwrites that same way. It never creates a second copy, and the set's other entries survive.
- R9: `flush` invalidates every entry at the clock edge. A lookup in the flush cycle reports a miss. A fill in the flush cycle is discarded.
- R10: After `rst`, which is synchronous and active high, every entry is invalid.
- R11: The four sets are independent, so eight pages, two per set, can be resident at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent, walk needed |
| lk_pte | output | 24 | Cached entry on hit, zero otherwise |
| lk_paddr | output | 32 | Physical address on hit, zero otherwise |
| fill_valid | input | 1 | Install request |
| fill_vpn | input | 20 | Page number of the installed entry |
| fill_pte | input | 24 | Entry to install |

## Verification
A lookup can share its cycle with a fill, and also with a flush. The bench provokes both collisions. It drives a lookup and a fill of the same page together and expects a miss in that cycle and a hit in the next. It drives a flush together with a lookup of a resident page and expects a miss. It also drives a flush together with a fill and expects the filled page to miss on the following cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        PICK_MATCH = 2'd0,
        PICK_EMPTY = 2'd1,
        PICK_LRU   = 2'd2
    } pick_e;

    function automatic int unsigned rotate_next(input int unsigned cur, input int unsigned ways);
        return (cur + 1 >= ways) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int TAG_W = 18,
    parameter int PTE_W = 24
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              flush,
    input  logic                              wr_en,
    input  logic [$clog2(SETS)-1:0]           wr_set,
    input  logic [$clog2(WAYS)-1:0]           wr_way,
    input  logic [TAG_W-1:0]                  wr_tag,
    input  logic [PTE_W-1:0]                  wr_pte,
    input  logic [$clog2(SETS)-1:0]           a_set,
    output logic [WAYS-1:0]                   a_valid,
    output logic [WAYS-1:0][TAG_W-1:0]        a_tag,
    output logic [WAYS-1:0][PTE_W-1:0]        a_pte,
    input  logic [$clog2(SETS)-1:0]           b_set,
    output logic [WAYS-1:0]                   b_valid,
    output logic [WAYS-1:0][TAG_W-1:0]        b_tag
);
    logic [SETS-1:0][WAYS-1:0]             vld_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [SETS-1:0][WAYS-1:0][PTE_W-1:0]  pte_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_q[wr_set][wr_way] <= wr_tag;
            pte_q[wr_set][wr_way] <= wr_pte;
        end
    end

    assign a_valid = vld_q[a_set];
    assign a_tag   = tag_q[a_set];
    assign a_pte   = pte_q[a_set];
    assign b_valid = vld_q[b_set];
    assign b_tag   = tag_q[b_set];

    // R5: a written way is valid on the following cycle
    assert_fill_marks_valid_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> vld_q[$past(wr_set)][$past(wr_way)]);

    // R9: nothing survives a flush
    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld_q == '0));

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 18
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WAYS-1:0]             row_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  row_tag,
    input  logic [TAG_W-1:0]            key_tag,
    output logic                        any_hit,
    output logic [$clog2(WAYS)-1:0]     hit_way
);
    localparam int WAY_IW = $clog2(WAYS);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = row_valid[w] && (row_tag[w] == key_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_IW'(w);
        end
    end

    assign any_hit = |match;

    // R8: a page never sits in two ways of one set
    assert_single_match_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

endmodule

// File: rtl/tlb_repl.sv
module tlb_repl
    import tlb_pkg::*;
#(
    parameter int SETS = 4,
    parameter int WAYS = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        hit_en,
    input  logic [$clog2(SETS)-1:0]     hit_set,
    input  logic [$clog2(WAYS)-1:0]     hit_way,
    input  logic                        fill_en,
    input  logic [$clog2(SETS)-1:0]     fill_set,
    input  logic [WAYS-1:0]             row_valid,
    input  logic                        row_match,
    input  logic [$clog2(WAYS)-1:0]     row_match_way,
    output logic [$clog2(WAYS)-1:0]     fill_way
);
    localparam int WAY_IW = $clog2(WAYS);

    logic [SETS-1:0][WAY_IW-1:0] mru_q;
    logic [WAY_IW-1:0]           empty_way;
    logic                        has_empty;
    logic [WAY_IW-1:0]           lru_way;
    pick_e                       pick;

    always_comb begin
        empty_way = '0;
        has_empty = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!has_empty && !row_valid[w]) begin
                empty_way = WAY_IW'(w);
                has_empty = 1'b1;
            end
        end
    end

    assign lru_way = WAY_IW'(rotate_next(int'(mru_q[fill_set]), WAYS));

    always_comb begin
        if (row_match)      pick = PICK_MATCH;
        else if (has_empty) pick = PICK_EMPTY;
        else                pick = PICK_LRU;
        case (pick)
            PICK_MATCH: fill_way = row_match_way;
            PICK_EMPTY: fill_way = empty_way;
            default:    fill_way = lru_way;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mru_q <= '0;
        end else begin
            if (hit_en)  mru_q[hit_set]  <= hit_way;
            if (fill_en) mru_q[fill_set] <= fill_way;
        end
    end

    // R6: a new page never lands on a valid way while an invalid one exists
    assert_empty_way_first_R6: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !row_match && !(&row_valid)) |-> !row_valid[fill_way]);

    // R8: a page already present is refilled in place
    assert_refill_in_place_R8: assert property (@(posedge clk) disable iff (rst)
        (fill_en && row_match) |-> (fill_way == row_match_way));

endmodule

// File: rtl/tlb_sa.sv
module tlb_sa #(
    parameter int VA_W   = 32,
    parameter int OFF_W  = 12,
    parameter int PPN_W  = 20,
    parameter int FLAG_W = 4,
    parameter int SETS   = 4,
    parameter int WAYS   = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        flush,
    input  logic                        lk_valid,
    input  logic [VA_W-1:0]             lk_vaddr,
    output logic                        lk_hit,
    output logic                        lk_miss,
    output logic [PPN_W+FLAG_W-1:0]     lk_pte,
    output logic [PPN_W+OFF_W-1:0]      lk_paddr,
    input  logic                        fill_valid,
    input  logic [VA_W-OFF_W-1:0]       fill_vpn,
    input  logic [PPN_W+FLAG_W-1:0]     fill_pte
);
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int SET_IW = $clog2(SETS);
    localparam int WAY_IW = $clog2(WAYS);
    localparam int TAG_W  = VPN_W - SET_IW;
    localparam int PTE_W  = PPN_W + FLAG_W;

    logic [VPN_W-1:0]              lk_vpn;
    logic [SET_IW-1:0]             lk_set, fl_set;
    logic [TAG_W-1:0]              lk_tag, fl_tag;
    logic [WAYS-1:0]               a_valid, b_valid;
    logic [WAYS-1:0][TAG_W-1:0]    a_tag, b_tag;
    logic [WAYS-1:0][PTE_W-1:0]    a_pte;
    logic                          a_hit, b_hit;
    logic [WAY_IW-1:0]             a_way, b_way, vic_way;
    logic                          fill_go;
    logic [PTE_W-1:0]              sel_pte;

    assign lk_vpn  = lk_vaddr[VA_W-1:OFF_W];
    assign lk_set  = lk_vpn[SET_IW-1:0];
    assign lk_tag  = lk_vpn[VPN_W-1:SET_IW];
    assign fl_set  = fill_vpn[SET_IW-1:0];
    assign fl_tag  = fill_vpn[VPN_W-1:SET_IW];
    assign fill_go = fill_valid && !flush;

    tlb_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PTE_W(PTE_W)) u_store (
        .clk(clk), .rst(rst), .flush(flush),
        .wr_en(fill_go), .wr_set(fl_set), .wr_way(vic_way), .wr_tag(fl_tag), .wr_pte(fill_pte),
        .a_set(lk_set), .a_valid(a_valid), .a_tag(a_tag), .a_pte(a_pte),
        .b_set(fl_set), .b_valid(b_valid), .b_tag(b_tag)
    );

    tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_lk (
        .clk(clk), .rst(rst), .row_valid(a_valid), .row_tag(a_tag), .key_tag(lk_tag),
        .any_hit(a_hit), .hit_way(a_way)
    );

    tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_fl (
        .clk(clk), .rst(rst), .row_valid(b_valid), .row_tag(b_tag), .key_tag(fl_tag),
        .any_hit(b_hit), .hit_way(b_way)
    );

    tlb_repl #(.SETS(SETS), .WAYS(WAYS)) u_repl (
        .clk(clk), .rst(rst),
        .hit_en(lk_hit), .hit_set(lk_set), .hit_way(a_way),
        .fill_en(fill_go), .fill_set(fl_set), .row_valid(b_valid),
        .row_match(b_hit), .row_match_way(b_way), .fill_way(vic_way)
    );

    assign sel_pte  = a_pte[a_way];
    assign lk_hit   = lk_valid && !flush && a_hit;
    assign lk_miss  = lk_valid && !lk_hit;
    assign lk_pte   = lk_hit ? sel_pte : '0;
    assign lk_paddr = lk_hit ? {sel_pte[PTE_W-1 -: PPN_W], lk_vaddr[OFF_W-1:0]} : '0;

    // R4: hit and miss never together
    assert_hit_miss_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_miss));

    // R4: no result without a request
    assert_idle_silent_R4: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && !lk_miss));

    // R9: the cycle after a flush cannot hit
    assert_no_hit_after_flush_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lk_hit);

endmodule

// File: tb/test_tlb_sa.sv
`timescale 1ns/1ps
module test_tlb_sa;
    logic        clk = 1'b0;
    logic        rst, flush, lk_valid, fill_valid;
    logic [31:0] lk_vaddr;
    logic [19:0] fill_vpn;
    logic [23:0] fill_pte;
    logic        lk_hit, lk_miss;
    logic [23:0] lk_pte;
    logic [31:0] lk_paddr;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    tlb_sa i_tlb_sa (
        .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pte(lk_pte), .lk_paddr(lk_paddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pte(fill_pte)
    );

    // row: {op[1:0] (0 lookup, 1 fill, 2 flush), vpn[19:0], off[11:0], pte[23:0], exp_hit}
    localparam int NV = 22;
    localparam logic [58:0] VEC [NV] = '{
        {2'd0, 20'h00004, 12'h123, 24'h000000, 1'b0}, // cold miss
        {2'd1, 20'h00004, 12'h000, 24'h111115, 1'b0}, // R6 way0
        {2'd0, 20'h00004, 12'hABC, 24'h111115, 1'b1},
        {2'd1, 20'h00008, 12'h000, 24'h222223, 1'b0}, // R6 way1
        {2'd0, 20'h00008, 12'h000, 24'h222223, 1'b1},
        {2'd0, 20'h00004, 12'hFFF, 24'h111115, 1'b1}, // 00008 now LRU
        {2'd1, 20'h0000C, 12'h000, 24'h333337, 1'b0}, // R7 evicts 00008
        {2'd0, 20'h00008, 12'h010, 24'h000000, 1'b0},
        {2'd0, 20'h00004, 12'h020, 24'h111115, 1'b1},
        {2'd0, 20'h0000C, 12'h030, 24'h333337, 1'b1},
        {2'd0, 20'h00004, 12'h040, 24'h111115, 1'b1}, // 0000C now LRU
        {2'd1, 20'h00004, 12'h000, 24'h444441, 1'b0}, // R8 refill in place
        {2'd0, 20'h00004, 12'h050, 24'h444441, 1'b1},
        {2'd0, 20'h0000C, 12'h060, 24'h333337, 1'b1}, // R8 neighbour survives
        {2'd1, 20'h00001, 12'h000, 24'h555550, 1'b0},
        {2'd0, 20'h00001, 12'h070, 24'h555550, 1'b1},
        {2'd0, 20'h00005, 12'h080, 24'h000000, 1'b0}, // R1 set differs
        {2'd0, 20'h80004, 12'h090, 24'h000000, 1'b0}, // R1 tag top bit differs
        {2'd0, 20'h00004, 12'h0A0, 24'h444441, 1'b1},
        {2'd2, 20'h00000, 12'h000, 24'h000000, 1'b0}, // R9 flush
        {2'd0, 20'h00004, 12'h0B0, 24'h000000, 1'b0},
        {2'd0, 20'h00001, 12'h0C0, 24'h000000, 1'b0}
    };

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic idle();
        flush = 1'b0; lk_valid = 1'b0; lk_vaddr = '0;
        fill_valid = 1'b0; fill_vpn = '0; fill_pte = '0;
    endtask

    // outputs already settled: check lookup result
    task automatic judge(input bit eh, input logic [23:0] ep, input logic [11:0] off, input string rq);
        chk(lk_hit == eh, {rq, " R2 hit"}, 32'(lk_hit), 32'(eh));
        chk(lk_miss == !eh, {rq, " R4 miss"}, 32'(lk_miss), 32'(!eh));
        if (eh) begin
            chk(lk_pte == ep, {rq, " R2 pte"}, 32'(lk_pte), 32'(ep));
            chk(lk_paddr == {ep[23:4], off}, {rq, " R3 paddr"}, lk_paddr, {ep[23:4], off});
        end
    endtask

    task automatic finish_cycle();
        @(posedge clk); #1; idle();
    endtask

    task automatic look(input logic [19:0] vpn, input logic [11:0] off, input bit eh,
                        input logic [23:0] ep, input string rq);
        @(negedge clk); lk_valid = 1'b1; lk_vaddr = {vpn, off}; #1;
        judge(eh, ep, off, rq);
        finish_cycle();
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [23:0] pte);
        @(negedge clk); fill_valid = 1'b1; fill_vpn = vpn; fill_pte = pte;
        finish_cycle();
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst = 1'b1;
        @(posedge clk); @(posedge clk); #1; rst = 1'b0;
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(); rst = 1'b1;
        do_reset();

        // R10 / R4: reset state, idle then lookup
        @(negedge clk); #1;
        chk(!lk_hit && !lk_miss, "R4 idle outputs", {lk_hit, lk_miss}, 0);
        look(20'h00004, 12'h0, 1'b0, 24'h0, "R10 after reset");

        // R11: eight pages across four sets, two tags each
        for (int i = 0; i < 8; i++) fill(20'(i), 24'h0A0000 + 24'(i << 4) + 24'(i));
        for (int i = 0; i < 8; i++) look(20'(i), 12'(i * 3), 1'b1, 24'h0A0000 + 24'(i << 4) + 24'(i), "R11 resident");

        do_reset();
        look(20'h00003, 12'h0, 1'b0, 24'h0, "R10 reset clears");

        // table walk
        for (int k = 0; k < NV; k++) begin
            logic [58:0] v;
            v = VEC[k];
            case (v[58:57])
                2'd0: look(v[56:37], v[36:25], v[0], v[24:1], "table");
                2'd1: fill(v[56:37], v[24:1]);
                default: begin
                    @(negedge clk); flush = 1'b1; finish_cycle();
                end
            endcase
        end

        // R9: lookup in the flush cycle misses
        fill(20'h00022, 24'h777772);
        look(20'h00022, 12'h5, 1'b1, 24'h777772, "R9 pre-flush");
        @(negedge clk); flush = 1'b1; lk_valid = 1'b1; lk_vaddr = {20'h00022, 12'h5}; #1;
        judge(1'b0, 24'h0, 12'h5, "R9 lookup during flush");
        finish_cycle();
        look(20'h00022, 12'h5, 1'b0, 24'h0, "R9 after flush");

        // R9: fill in the flush cycle is dropped
        @(negedge clk); flush = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h00033; fill_pte = 24'h888881;
        finish_cycle();
        look(20'h00033, 12'h0, 1'b0, 24'h0, "R9 fill discarded");

        // R5: lookup and fill of the same page together
        @(negedge clk); lk_valid = 1'b1; lk_vaddr = {20'h00046, 12'h9};
        fill_valid = 1'b1; fill_vpn = 20'h00046; fill_pte = 24'h999990; #1;
        judge(1'b0, 24'h0, 12'h9, "R5 same-cycle fill");
        finish_cycle();
        look(20'h00046, 12'h9, 1'b1, 24'h999990, "R5 next cycle");

        // R10: reset in mid-run drops resident pages
        do_reset();
        look(20'h00046, 12'h9, 1'b0, 24'h0, "R10 mid-run reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule